// File: doc/BRIEF.md
# Clocked Serial Frame Receiver with Break Tracking

This block listens passively on a two-wire debug link made of a link clock and a half-duplex data line. Both wires are brought into the system clock domain, and the block finds the edges of the link clock there. It captures the data line on each rising link-clock edge and closes a bit slot on each falling edge. The resulting bit stream is assembled into 11-bit frames. Each completed frame is checked for parity and for a correct stop bit. A byte is handed upward only when both checks are clean.

The block also tracks runs of low bits independently of frame boundaries. A run of eleven or more low bits is a break. It is reported with a single strobe once the line returns high. That high bit then does not begin a new frame. Any frame left half assembled when the break is recognised is thrown away. All results are one-cycle pulses in the system clock domain. The system clock must run at least four times faster than the link clock.

Top module: `link_frame_rx`

## Requirements
- R1: After a synchronous active-high reset, byte_valid, parity_err, stop_err and brk are all low, and no frame or break state is retained.
- R2: A bit takes the data-line value captured at the rising link-clock edge. The bit is delivered at the following falling edge. The first falling edge after reset only opens a slot and delivers no bit.
- R3: A frame is, in time order, one low start bit, 8 data bits with the least significant first, one parity bit and one stop bit. On a good frame, byte_data carries the data bits with the first data bit in byte_data[0].
- R4: Parity is even. When the 8 data bits and the parity bit together hold an odd number of ones, parity_err pulses for that frame.
- R5: A stop bit that reads low makes stop_err pulse for that frame.
- R6: byte_valid pulses only for a frame with good parity and a high stop bit. Bad frames still pulse their error flags. Every output pulse lasts one system clock cycle.
- R7: While no frame is in progress, high bits are ignored and the first low bit starts a frame. A second stop bit is therefore absorbed as idle.
- R8: Eleven consecutive low bits at any alignment make a break pending, and further low bits extend it. brk pulses once, on the first high bit afterwards, and never while the line is still low.
- R9: When a break becomes pending, the partially assembled frame is discarded. Neither the low bits of the break nor the high bit that ends it produce a frame.
- R10: A run of only ten low bits followed by a high bit is not a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_clk | input | 1 | Link clock, asynchronous to clk |
| link_data | input | 1 | Link data line, asynchronous to clk |
| byte_valid | output | 1 | One-cycle strobe for a good frame |
| byte_data | output | DATA_BITS | Data byte of the last good frame |
| parity_err | output | 1 | One-cycle strobe, parity mismatch |
| stop_err | output | 1 | One-cycle strobe, low stop bit |
| brk | output | 1 | One-cycle strobe, break ended |

## Verification
A wrong bit counter or a misplaced shift shows at once as a wrong byte_data value, or as error strobes on the next frame. The first-slot rule is probed by leading a frame with a lost low bit. If that bit were kept, the frame would be misaligned by one position. A faulty zero counter shows within eleven link bits: either brk never appears, or a ten-bit run produces a spurious brk. Break cleanup faults show on the very next frame as a missing or corrupted byte.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    typedef enum logic {
        ASM_IDLE    = 1'b0,
        ASM_COLLECT = 1'b1
    } asm_state_e;

    localparam int LFR_DEF_DATA_BITS   = 8;
    localparam int LFR_DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/lfr_sync.sv
module lfr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lfr_slot.sv
module lfr_slot (
    input  logic clk,
    input  logic rst,
    input  logic lclk_s,
    input  logic ldat_s,
    output logic bit_vld,
    output logic bit_val
);
    typedef struct packed {
        logic prev;
        logic sample;
        logic opened;
        logic vld;
        logic val;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d      = slot_q;
        slot_d.vld  = 1'b0;
        slot_d.prev = lclk_s;
        if (lclk_s && !slot_q.prev) begin
            slot_d.sample = ldat_s;
        end
        if (!lclk_s && slot_q.prev) begin
            slot_d.opened = 1'b1;
            if (slot_q.opened) begin
                slot_d.vld = 1'b1;
                slot_d.val = slot_q.sample;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign bit_vld = slot_q.vld;
    assign bit_val = slot_q.val;
endmodule

// File: rtl/lfr_frame.sv
module lfr_frame
    import lfr_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int BREAK_LEN = DATA_BITS + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_vld,
    input  logic                 bit_val,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 parity_err,
    output logic                 stop_err,
    output logic                 brk
);
    localparam int FRAME_BITS = DATA_BITS + 3;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int ZC_W       = $clog2(BREAK_LEN + 1);

    typedef struct packed {
        asm_state_e              st;
        logic [CNT_W-1:0]        cnt;
        logic [FRAME_BITS-1:0]   sh;
        logic [ZC_W-1:0]         zc;
        logic                    pend;
        logic                    vld;
        logic [DATA_BITS-1:0]    data;
        logic                    pe;
        logic                    se;
        logic                    brk;
    } frm_t;

    frm_t frm_d, frm_q;

    logic [ZC_W-1:0]       zc_next;
    logic [CNT_W-1:0]      cnt_inc;
    logic [FRAME_BITS-1:0] sh_next;
    logic [DATA_BITS-1:0]  fr_data;
    logic                  fr_par;
    logic                  fr_stop;
    logic                  fr_pe;

    always_comb begin
        sh_next = {bit_val, frm_q.sh[FRAME_BITS-1:1]};
        fr_data = sh_next[DATA_BITS:1];
        fr_par  = sh_next[DATA_BITS+1];
        fr_stop = sh_next[DATA_BITS+2];
        fr_pe   = ^{fr_data, fr_par};
        cnt_inc = frm_q.cnt + 1'b1;
        if (bit_val)                           zc_next = '0;
        else if (frm_q.zc == ZC_W'(BREAK_LEN)) zc_next = frm_q.zc;
        else                                   zc_next = frm_q.zc + 1'b1;

        frm_d     = frm_q;
        frm_d.vld = 1'b0;
        frm_d.pe  = 1'b0;
        frm_d.se  = 1'b0;
        frm_d.brk = 1'b0;

        if (bit_vld) begin
            frm_d.zc = zc_next;
            if (frm_q.pend) begin
                if (bit_val) begin
                    frm_d.brk  = 1'b1;
                    frm_d.pend = 1'b0;
                end
                frm_d.st  = ASM_IDLE;
                frm_d.cnt = '0;
            end else if (zc_next == ZC_W'(BREAK_LEN)) begin
                frm_d.pend = 1'b1;
                frm_d.st   = ASM_IDLE;
                frm_d.cnt  = '0;
            end else if (frm_q.st == ASM_COLLECT || !bit_val) begin
                frm_d.sh  = sh_next;
                frm_d.cnt = cnt_inc;
                frm_d.st  = ASM_COLLECT;
                if (cnt_inc == CNT_W'(FRAME_BITS)) begin
                    frm_d.st  = ASM_IDLE;
                    frm_d.cnt = '0;
                    frm_d.pe  = fr_pe;
                    frm_d.se  = !fr_stop;
                    if (!fr_pe && fr_stop) begin
                        frm_d.vld  = 1'b1;
                        frm_d.data = fr_data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) frm_q <= '0;
        else     frm_q <= frm_d;
    end

    assign byte_valid = frm_q.vld;
    assign byte_data  = frm_q.data;
    assign parity_err = frm_q.pe;
    assign stop_err   = frm_q.se;
    assign brk        = frm_q.brk;
endmodule

// File: rtl/link_frame_rx.sv
module link_frame_rx
    import lfr_pkg::*;
#(
    parameter int SYNC_STAGES = LFR_DEF_SYNC_STAGES,
    parameter int DATA_BITS   = LFR_DEF_DATA_BITS,
    parameter int BREAK_LEN   = DATA_BITS + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 link_clk,
    input  logic                 link_data,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 parity_err,
    output logic                 stop_err,
    output logic                 brk
);
    logic lclk_s, ldat_s, bit_vld, bit_val;

    lfr_sync #(.STAGES(SYNC_STAGES)) clk_sync_i (
        .clk(clk), .rst(rst), .async_in(link_clk), .sync_out(lclk_s)
    );

    lfr_sync #(.STAGES(SYNC_STAGES)) dat_sync_i (
        .clk(clk), .rst(rst), .async_in(link_data), .sync_out(ldat_s)
    );

    lfr_slot slot_i (
        .clk(clk), .rst(rst), .lclk_s(lclk_s), .ldat_s(ldat_s),
        .bit_vld(bit_vld), .bit_val(bit_val)
    );

    lfr_frame #(.DATA_BITS(DATA_BITS), .BREAK_LEN(BREAK_LEN)) frame_i (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .parity_err(parity_err), .stop_err(stop_err), .brk(brk)
    );
endmodule

// File: rtl/lfr_checker.sv
module lfr_checker (
    input logic clk,
    input logic rst,
    input logic byte_valid,
    input logic parity_err,
    input logic stop_err,
    input logic brk
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !(byte_valid || parity_err || stop_err || brk));

    assert_valid_clean_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !(parity_err || stop_err));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    assert_perr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> !parity_err);

    assert_serr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        stop_err |=> !stop_err);

    assert_brk_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        brk |=> !brk);

    assert_brk_alone_R9: assert property (@(posedge clk) disable iff (rst)
        brk |-> !(byte_valid || parity_err || stop_err));
endmodule

bind link_frame_rx lfr_checker chk_i (
    .clk(clk), .rst(rst), .byte_valid(byte_valid),
    .parity_err(parity_err), .stop_err(stop_err), .brk(brk)
);

// File: tb/link_frame_rx_tb_top.sv
module link_frame_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_clk = 1'b0;
    logic       link_data = 1'b1;
    logic       byte_valid, parity_err, stop_err, brk;
    logic [7:0] byte_data;

    int checks = 0;
    int fails  = 0;
    int n_vld = 0, n_pe = 0, n_se = 0, n_brk = 0;
    logic [7:0] last_data = 8'h00;
    int s_vld, s_pe, s_se, s_brk;

    always #2.5 clk = ~clk;

    link_frame_rx dut_i (
        .clk(clk), .rst(rst), .link_clk(link_clk), .link_data(link_data),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .parity_err(parity_err), .stop_err(stop_err), .brk(brk)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                n_vld <= n_vld + 1;
                last_data <= byte_data;
            end
            if (parity_err) n_pe  <= n_pe + 1;
            if (stop_err)   n_se  <= n_se + 1;
            if (brk)        n_brk <= n_brk + 1;
        end
    end

    // data, parity, stop, expected valid, parity error, stop error
    localparam logic [12:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        link_data = b;
        repeat (4) @(negedge clk);
        link_clk = 1'b1;
        repeat (4) @(negedge clk);
        link_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic p, input logic s);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(p);
        send_bit(s);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic snap();
        s_vld = n_vld; s_pe = n_pe; s_se = n_se; s_brk = n_brk;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        link_clk = 1'b0;
        link_data = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 byte_valid", int'(byte_valid), 0);
        check("R1 parity_err", int'(parity_err), 0);
        check("R1 stop_err", int'(stop_err), 0);
        check("R1 brk", int'(brk), 0);
        rst = 1'b0;
        send_bit(1'b1);
        settle();

        // R3 R4 R5 R6: table of frames
        for (int v = 0; v < 6; v++) begin
            snap();
            send_frame(VEC[v][12:5], VEC[v][4], VEC[v][3]);
            send_bit(1'b1);
            settle();
            check("R6 valid count", n_vld - s_vld, int'(VEC[v][2]));
            check("R4 parity count", n_pe - s_pe, int'(VEC[v][1]));
            check("R5 stop count", n_se - s_se, int'(VEC[v][0]));
            if (VEC[v][2]) check("R3 data", int'(last_data), int'(VEC[v][12:5]));
        end

        // R7: idle high bits ignored
        snap();
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        settle();
        check("R7 idle valid", n_vld - s_vld, 0);
        check("R7 idle errors", (n_pe - s_pe) + (n_se - s_se) + (n_brk - s_brk), 0);

        // R7: second stop bit absorbed, next frame immediately follows
        snap();
        send_frame(8'h33, 1'b0, 1'b1);
        send_bit(1'b1);
        send_frame(8'hC3, 1'b0, 1'b1);
        send_bit(1'b1);
        settle();
        check("R7 two frames", n_vld - s_vld, 2);
        check("R7 second data", int'(last_data), 8'hC3);

        // R10: ten zeros then high is a frame, not a break
        snap();
        send_frame(8'h00, 1'b0, 1'b1);
        send_bit(1'b1);
        settle();
        check("R10 no brk", n_brk - s_brk, 0);
        check("R10 zero byte", n_vld - s_vld, 1);
        check("R10 data", int'(last_data), 0);

        // R8 R9: break starting at a frame start, held for 15 low bits
        snap();
        for (int i = 0; i < 15; i++) send_bit(1'b0);
        settle();
        check("R8 brk while low", n_brk - s_brk, 0);
        check("R9 no frame inside break", (n_vld - s_vld) + (n_pe - s_pe) + (n_se - s_se), 0);
        send_bit(1'b1);
        settle();
        check("R8 brk after high", n_brk - s_brk, 1);
        check("R9 closing high not start", (n_vld - s_vld) + (n_pe - s_pe) + (n_se - s_se), 0);
        snap();
        send_frame(8'h96, 1'b0, 1'b1);
        send_bit(1'b1);
        settle();
        check("R9 frame after break", n_vld - s_vld, 1);
        check("R9 data after break", int'(last_data), 8'h96);

        // R8: break not aligned to a frame (frame 0x01 completes inside run)
        snap();
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 0; i < 13; i++) send_bit(1'b0);
        send_bit(1'b1);
        settle();
        check("R8 unaligned brk", n_brk - s_brk, 1);
        check("R4 unaligned parity", n_pe - s_pe, 1);
        check("R5 unaligned stop", n_se - s_se, 1);
        check("R8 unaligned valid", n_vld - s_vld, 0);

        // R2: first falling edge after reset yields no bit
        do_reset();
        check("R1 after reset brk", int'(brk), 0);
        snap();
        send_bit(1'b0);
        send_frame(8'h5A, 1'b0, 1'b1);
        send_bit(1'b1);
        settle();
        check("R2 first slot dropped", n_vld - s_vld, 1);
        check("R2 data aligned", int'(last_data), 8'h5A);
        check("R2 no errors", (n_pe - s_pe) + (n_se - s_se), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule